// File: doc/BRIEF.md
# Dual-Port Burst RAM

A behavioural, synthesizable true dual-port memory in which each of two ports runs on its own clock and can reach every word, including a word the other port is using in the same cycle. Every port samples its address, write data and controls on its rising clock edge. An address counter in each port can be cleared, loaded from the address pins, held, or stepped by one. A host can therefore stream a burst of consecutive words after presenting only the first address.

Each port has two chip enables, one active low and one active high, and an active-low select for each byte lane. Read data leaves the block with a per-lane drive enable in place of a three-state bus. An asynchronous output enable gates that drive enable. A per-port mode input chooses flow-through timing, with data one clock after the access, or pipelined timing, with data one clock later than that. The depth is `2**ADDR_W` words. The default build is small. The full 16384-word part uses `ADDR_W = 14`.

If both ports write the same byte of the same word in the same cycle, that byte holds an undefined value until it is written again.

Top module: `dual_port_burst_ram`

## Requirements
- R1: Either port can write and read any word. A word written through one port reads back through the other port. A read in the same cycle that the other port writes that word returns the word's previous contents.
- R2: Address, write data, selects, read/write and counter controls are sampled at the rising edge of the port's own clock.
- R3: A port is selected only when `x_sel_n` is 0 and `x_sel` is 1. A deselected port writes nothing and drives no read lane.
- R4: `x_hi_n` (active low) controls bits 15:8 and drive bit 1. `x_lo_n` (active low) controls bits 7:0 and drive bit 0. A write changes only the selected lanes. A read drives only the selected lanes. With both selects high, no lane is read or written.
- R5: `x_rd_wr` = 1 makes a read access and `x_rd_wr` = 0 makes a write access.
- R6: `x_out_en_n` acts without a clock. When it is 1, both drive bits are 0 at once. It does not affect writes or the data that is waiting to be driven.
- R7: With `x_pipe_mode` = 0, the data of the access sampled at edge k is driven from edge k until edge k+1. With `x_pipe_mode` = 1, it is driven from edge k+1 until edge k+2. Each port has its own mode.
- R8: `x_clr_n` = 0 makes the access use word 0 and sets the counter to 0, whatever the load and advance inputs are.
- R9: `x_load_n` = 0 (with `x_clr_n` = 1) makes the access use the external address and stores it in the counter. With `x_load_n` = 1 and `x_adv_n` = 1, the counter holds, its value is the access address, and the external address is ignored.
- R10: `x_adv_n` = 0 with `x_load_n` = 1 makes the access use counter+1 and stores that value. The counter wraps from the last word to 0.
- R11: Clear, load and advance act whether or not the port is selected and whatever its byte selects are.
- R12: When `x_load_n` and `x_adv_n` are both 0, the load wins.
- R13: While `rst_n` is 0, both counters are 0 and no read lane is driven. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of counters and read stages |
| a_clk | input | 1 | Port A clock |
| a_addr | input | ADDR_W | Port A external address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data |
| a_drive | output | 2 | Port A per-lane drive enable (bit 1 upper, bit 0 lower) |
| a_sel_n | input | 1 | Port A active-low chip enable |
| a_sel | input | 1 | Port A active-high chip enable |
| a_rd_wr | input | 1 | Port A 1 = read, 0 = write |
| a_hi_n | input | 1 | Port A upper-lane select, active low |
| a_lo_n | input | 1 | Port A lower-lane select, active low |
| a_out_en_n | input | 1 | Port A asynchronous output enable, active low |
| a_load_n | input | 1 | Port A address load strobe, active low |
| a_adv_n | input | 1 | Port A counter advance, active low |
| a_clr_n | input | 1 | Port A counter clear, active low |
| a_pipe_mode | input | 1 | Port A 0 = flow-through, 1 = pipelined |
| b_clk | input | 1 | Port B clock |
| b_addr | input | ADDR_W | Port B external address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data |
| b_drive | output | 2 | Port B per-lane drive enable |
| b_sel_n | input | 1 | Port B active-low chip enable |
| b_sel | input | 1 | Port B active-high chip enable |
| b_rd_wr | input | 1 | Port B 1 = read, 0 = write |
| b_hi_n | input | 1 | Port B upper-lane select, active low |
| b_lo_n | input | 1 | Port B lower-lane select, active low |
| b_out_en_n | input | 1 | Port B asynchronous output enable, active low |
| b_load_n | input | 1 | Port B address load strobe, active low |
| b_adv_n | input | 1 | Port B counter advance, active low |
| b_clr_n | input | 1 | Port B counter clear, active low |
| b_pipe_mode | input | 1 | Port B 0 = flow-through, 1 = pipelined |

## Verification
A counter that clears, loads, holds or steps wrongly makes the port access the wrong word. This shows as wrong read data one clock later in flow-through mode and two clocks later in pipelined mode. A write to the wrong word stays hidden until that word is read again. A wrong lane mask or a stuck read stage shows at once, in the drive enables of the cycle that should present the data. A fault in the XOR storage appears only when a word written by one port is read back. For that reason the stimulus keeps addresses in a small window, so that the two ports hit each other's words often.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  localparam int unsigned LANES = 2;

  typedef logic [LANES-1:0] lane_t;

  typedef enum logic {
    RD_FLOW = 1'b0,
    RD_PIPE = 1'b1
  } rd_mode_e;

  // Port is live only with the low enable asserted and the high enable asserted.
  function automatic logic port_on(input logic sel_n, input logic sel);
    return !sel_n && sel;
  endfunction

  // Bit 1 is the upper lane, bit 0 the lower lane.
  function automatic lane_t lane_pick(input logic hi_n, input logic lo_n);
    return {~hi_n, ~lo_n};
  endfunction

  function automatic lane_t lane_gate(input lane_t lanes, input logic out_en_n);
    return out_en_n ? '0 : lanes;
  endfunction

endpackage

// File: rtl/dpr_burst_ctr.sv
module dpr_burst_ctr #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              load_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] use_addr,
  output logic [ADDR_W-1:0] cnt_q
);

  // Clear beats load, load beats advance, otherwise hold.
  function automatic logic [ADDR_W-1:0] pick_addr(
    input logic [ADDR_W-1:0] cur,
    input logic [ADDR_W-1:0] ext,
    input logic              c_n,
    input logic              l_n,
    input logic              a_n
  );
    if (!c_n)      return '0;
    else if (!l_n) return ext;
    else if (!a_n) return cur + ADDR_W'(1);
    else           return cur;
  endfunction

  always_comb use_addr = pick_addr(cnt_q, ext_addr, clr_n, load_n, adv_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= use_addr;
  end

endmodule

// File: rtl/dpr_port.sv
module dpr_port
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              rd_wr,
  input  logic              hi_n,
  input  logic              lo_n,
  input  logic              out_en_n,
  input  logic              load_n,
  input  logic              adv_n,
  input  logic              clr_n,
  input  logic              pipe_mode,
  output logic [ADDR_W-1:0] mem_addr,
  output lane_t             mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rdata,
  output lane_t             drive,
  output logic [ADDR_W-1:0] cnt_q
);

  logic     live;
  lane_t    lanes;
  rd_mode_e mode;

  lane_t             s1_lanes, s2_lanes;
  logic [DATA_W-1:0] s1_data,  s2_data;
  lane_t             out_lanes;

  dpr_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .adv_n    (adv_n),
    .ext_addr (addr),
    .use_addr (mem_addr),
    .cnt_q    (cnt_q)
  );

  assign live      = port_on(sel_n, sel);
  assign lanes     = lane_pick(hi_n, lo_n);
  assign mem_we    = (live && !rd_wr) ? lanes : '0;
  assign mem_wdata = wdata;
  assign mode      = rd_mode_e'(pipe_mode);

  // Lane-valid flags carry the reset; data registers do not need one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_lanes <= '0;
      s2_lanes <= '0;
    end else begin
      s1_lanes <= (live && rd_wr) ? lanes : '0;
      s2_lanes <= s1_lanes;
    end
  end

  always_ff @(posedge clk) begin
    s1_data <= mem_rdata;
    s2_data <= s1_data;
  end

  always_comb begin
    unique case (mode)
      RD_PIPE: begin out_lanes = s2_lanes; rdata = s2_data; end
      default: begin out_lanes = s1_lanes; rdata = s1_data; end
    endcase
  end

  assign drive = lane_gate(out_lanes, out_en_n);

endmodule

// File: rtl/dpr_xor_store.sv
module dpr_xor_store
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk0,
  input  logic              clk1,
  input  logic [ADDR_W-1:0] addr0,
  input  logic [ADDR_W-1:0] addr1,
  input  lane_t             we0,
  input  lane_t             we1,
  input  logic [DATA_W-1:0] wdata0,
  input  logic [DATA_W-1:0] wdata1,
  output logic [DATA_W-1:0] rdata0,
  output logic [DATA_W-1:0] rdata1
);

  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned LANE_W = DATA_W / LANES;

  // Each bank has a single writer; a word is the XOR of both banks.
  logic [DATA_W-1:0] bank0 [DEPTH];
  logic [DATA_W-1:0] bank1 [DEPTH];

  assign rdata0 = bank0[addr0] ^ bank1[addr0];
  assign rdata1 = bank0[addr1] ^ bank1[addr1];

  always_ff @(posedge clk0) begin
    for (int l = 0; l < LANES; l++) begin
      if (we0[l])
        bank0[addr0][l*LANE_W +: LANE_W] <= wdata0[l*LANE_W +: LANE_W] ^ bank1[addr0][l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk1) begin
    for (int l = 0; l < LANES; l++) begin
      if (we1[l])
        bank1[addr1][l*LANE_W +: LANE_W] <= wdata1[l*LANE_W +: LANE_W] ^ bank0[addr1][l*LANE_W +: LANE_W];
    end
  end

endmodule

// File: rtl/dual_port_burst_ram.sv
module dual_port_burst_ram
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16
) (
  input  logic              rst_n,
  input  logic              a_clk,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic [1:0]        a_drive,
  input  logic              a_sel_n,
  input  logic              a_sel,
  input  logic              a_rd_wr,
  input  logic              a_hi_n,
  input  logic              a_lo_n,
  input  logic              a_out_en_n,
  input  logic              a_load_n,
  input  logic              a_adv_n,
  input  logic              a_clr_n,
  input  logic              a_pipe_mode,
  input  logic              b_clk,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic [1:0]        b_drive,
  input  logic              b_sel_n,
  input  logic              b_sel,
  input  logic              b_rd_wr,
  input  logic              b_hi_n,
  input  logic              b_lo_n,
  input  logic              b_out_en_n,
  input  logic              b_load_n,
  input  logic              b_adv_n,
  input  logic              b_clr_n,
  input  logic              b_pipe_mode
);

  localparam int unsigned NPORT = 2;

  // Port-indexed views of the pins and of internal events.
  logic [NPORT-1:0]             clk_v, sel_n_v, sel_v, rd_wr_v, hi_n_v, lo_n_v;
  logic [NPORT-1:0]             out_en_n_v, load_n_v, adv_n_v, clr_n_v, pipe_v;
  logic [NPORT-1:0][ADDR_W-1:0] addr_v, mem_addr_v, cnt_v;
  logic [NPORT-1:0][DATA_W-1:0] wdata_v, mem_wdata_v, mem_rdata_v, rdata_v;
  lane_t [NPORT-1:0]            we_v, drive_v;

  assign clk_v      = {b_clk,      a_clk};
  assign sel_n_v    = {b_sel_n,    a_sel_n};
  assign sel_v      = {b_sel,      a_sel};
  assign rd_wr_v    = {b_rd_wr,    a_rd_wr};
  assign hi_n_v     = {b_hi_n,     a_hi_n};
  assign lo_n_v     = {b_lo_n,     a_lo_n};
  assign out_en_n_v = {b_out_en_n, a_out_en_n};
  assign load_n_v   = {b_load_n,   a_load_n};
  assign adv_n_v    = {b_adv_n,    a_adv_n};
  assign clr_n_v    = {b_clr_n,    a_clr_n};
  assign pipe_v     = {b_pipe_mode, a_pipe_mode};
  assign addr_v     = {b_addr,     a_addr};
  assign wdata_v    = {b_wdata,    a_wdata};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk       (clk_v[p]),
      .rst_n     (rst_n),
      .addr      (addr_v[p]),
      .wdata     (wdata_v[p]),
      .sel_n     (sel_n_v[p]),
      .sel       (sel_v[p]),
      .rd_wr     (rd_wr_v[p]),
      .hi_n      (hi_n_v[p]),
      .lo_n      (lo_n_v[p]),
      .out_en_n  (out_en_n_v[p]),
      .load_n    (load_n_v[p]),
      .adv_n     (adv_n_v[p]),
      .clr_n     (clr_n_v[p]),
      .pipe_mode (pipe_v[p]),
      .mem_addr  (mem_addr_v[p]),
      .mem_we    (we_v[p]),
      .mem_wdata (mem_wdata_v[p]),
      .mem_rdata (mem_rdata_v[p]),
      .rdata     (rdata_v[p]),
      .drive     (drive_v[p]),
      .cnt_q     (cnt_v[p])
    );
  end

  dpr_xor_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk0   (clk_v[0]),
    .clk1   (clk_v[1]),
    .addr0  (mem_addr_v[0]),
    .addr1  (mem_addr_v[1]),
    .we0    (we_v[0]),
    .we1    (we_v[1]),
    .wdata0 (mem_wdata_v[0]),
    .wdata1 (mem_wdata_v[1]),
    .rdata0 (mem_rdata_v[0]),
    .rdata1 (mem_rdata_v[1])
  );

  assign a_rdata = rdata_v[0];
  assign b_rdata = rdata_v[1];
  assign a_drive = drive_v[0];
  assign b_drive = drive_v[1];

endmodule

// File: rtl/dpr_chk.sv
module dpr_chk #(
  parameter int unsigned ADDR_W = 11
) (
  input logic                   rst_n,
  input logic [1:0]             clk_v,
  input logic [1:0]             sel_n_v,
  input logic [1:0]             sel_v,
  input logic [1:0]             out_en_n_v,
  input logic [1:0]             load_n_v,
  input logic [1:0]             adv_n_v,
  input logic [1:0]             clr_n_v,
  input logic [1:0][ADDR_W-1:0] addr_v,
  input logic [1:0][ADDR_W-1:0] cnt_v,
  input logic [1:0][1:0]        we_v,
  input logic [1:0][1:0]        drive_v
);

  for (genvar p = 0; p < 2; p++) begin : g_chk
    // R8
    clr_to_zero_chk: assert property (@(posedge clk_v[p]) disable iff (!rst_n)
      !clr_n_v[p] |=> cnt_v[p] == '0);

    // R12
    load_wins_chk: assert property (@(posedge clk_v[p]) disable iff (!rst_n)
      (clr_n_v[p] && !load_n_v[p]) |=> cnt_v[p] == $past(addr_v[p]));

    // R9
    hold_chk: assert property (@(posedge clk_v[p]) disable iff (!rst_n)
      (clr_n_v[p] && load_n_v[p] && adv_n_v[p]) |=> $stable(cnt_v[p]));

    // R10
    advance_wrap_chk: assert property (@(posedge clk_v[p]) disable iff (!rst_n)
      (clr_n_v[p] && load_n_v[p] && !adv_n_v[p]) |=> cnt_v[p] == ADDR_W'($past(cnt_v[p]) + 1));

    // R3
    desel_no_write_chk: assert property (@(posedge clk_v[p]) disable iff (!rst_n)
      (sel_n_v[p] || !sel_v[p]) |-> we_v[p] == 2'b00);

    // R6
    oe_gate_chk: assert property (@(posedge clk_v[p]) disable iff (!rst_n)
      out_en_n_v[p] |-> drive_v[p] == 2'b00);
  end

endmodule

bind dual_port_burst_ram dpr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .rst_n      (rst_n),
  .clk_v      (clk_v),
  .sel_n_v    (sel_n_v),
  .sel_v      (sel_v),
  .out_en_n_v (out_en_n_v),
  .load_n_v   (load_n_v),
  .adv_n_v    (adv_n_v),
  .clr_n_v    (clr_n_v),
  .addr_v     (addr_v),
  .cnt_v      (cnt_v),
  .we_v       (we_v),
  .drive_v    (drive_v)
);

// File: tb/dual_port_burst_ram_tb.sv
module dual_port_burst_ram_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 11;
  localparam int DATA_W     = 16;
  localparam int DEPTH      = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [ADDR_W-1:0] p_addr [2];
  logic [DATA_W-1:0] p_wdata [2];
  logic              p_sel_n [2], p_sel [2], p_rdwr [2], p_hi_n [2], p_lo_n [2];
  logic              p_oen [2], p_load_n [2], p_adv_n [2], p_clr_n [2], p_pipe [2];
  logic [DATA_W-1:0] o_rdata [2];
  logic [1:0]        o_drive [2];

  dual_port_burst_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .rst_n(rst_n),
    .a_clk(clk), .a_addr(p_addr[0]), .a_wdata(p_wdata[0]), .a_rdata(o_rdata[0]), .a_drive(o_drive[0]),
    .a_sel_n(p_sel_n[0]), .a_sel(p_sel[0]), .a_rd_wr(p_rdwr[0]), .a_hi_n(p_hi_n[0]), .a_lo_n(p_lo_n[0]),
    .a_out_en_n(p_oen[0]), .a_load_n(p_load_n[0]), .a_adv_n(p_adv_n[0]), .a_clr_n(p_clr_n[0]),
    .a_pipe_mode(p_pipe[0]),
    .b_clk(clk), .b_addr(p_addr[1]), .b_wdata(p_wdata[1]), .b_rdata(o_rdata[1]), .b_drive(o_drive[1]),
    .b_sel_n(p_sel_n[1]), .b_sel(p_sel[1]), .b_rd_wr(p_rdwr[1]), .b_hi_n(p_hi_n[1]), .b_lo_n(p_lo_n[1]),
    .b_out_en_n(p_oen[1]), .b_load_n(p_load_n[1]), .b_adv_n(p_adv_n[1]), .b_clr_n(p_clr_n[1]),
    .b_pipe_mode(p_pipe[1])
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Bench model
  logic [DATA_W-1:0] m_mem   [DEPTH];
  logic [1:0]        m_known [DEPTH];
  logic [ADDR_W-1:0] m_cnt [2];
  logic [1:0]        s1_l [2], s2_l [2], s1_k [2], s2_k [2];
  logic [DATA_W-1:0] s1_d [2], s2_d [2];
  string             s1_t [2], s2_t [2];

  function automatic logic [ADDR_W-1:0] ref_addr(input logic [ADDR_W-1:0] cnt, input logic [ADDR_W-1:0] ext,
                                                 input logic c_n, input logic l_n, input logic a_n);
    logic [ADDR_W-1:0] r;
    r = cnt;
    if (!a_n) r = ADDR_W'(cnt + 1);
    if (!l_n) r = ext;
    if (!c_n) r = '0;
    return r;
  endfunction

  function automatic string op_tag(input logic c_n, input logic l_n, input logic a_n);
    if (!c_n)              return "R1 R2 R5 R7 R8 clear";
    if (!l_n && !a_n)      return "R1 R2 R5 R7 R12 load+advance";
    if (!l_n)              return "R1 R2 R5 R7 R9 load";
    if (!a_n)              return "R1 R2 R5 R7 R10 advance";
    return "R1 R2 R5 R7 R9 hold";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drv(input int p, input logic c_n, input logic l_n, input logic a_n, input int addr,
                     input logic on, input logic rd, input logic hn, input logic ln,
                     input logic [DATA_W-1:0] wd, input logic oen, input logic pipe);
    p_clr_n[p] = c_n; p_load_n[p] = l_n; p_adv_n[p] = a_n; p_addr[p] = ADDR_W'(addr);
    p_sel_n[p] = !on; p_sel[p] = on; p_rdwr[p] = rd; p_hi_n[p] = hn; p_lo_n[p] = ln;
    p_wdata[p] = wd; p_oen[p] = oen; p_pipe[p] = pipe;
  endtask

  task automatic idle(input int p, input logic pipe);
    drv(p, 1'b1, 1'b1, 1'b1, 0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, pipe);
  endtask

  task automatic step();
    logic [ADDR_W-1:0] eff [2];
    logic              on [2];
    logic [1:0]        ln [2];
    logic [1:0]        nl [2], nk [2];
    logic [DATA_W-1:0] nd [2];
    string             nt [2];
    @(posedge clk);
    for (int p = 0; p < 2; p++) begin
      eff[p] = ref_addr(m_cnt[p], p_addr[p], p_clr_n[p], p_load_n[p], p_adv_n[p]);
      on[p]  = !p_sel_n[p] && p_sel[p];
      ln[p]  = {!p_hi_n[p], !p_lo_n[p]};
      nl[p]  = (on[p] && p_rdwr[p]) ? ln[p] : 2'b00;
      nd[p]  = m_mem[eff[p]];
      nk[p]  = m_known[eff[p]];
      nt[p]  = op_tag(p_clr_n[p], p_load_n[p], p_adv_n[p]);
    end
    for (int p = 0; p < 2; p++) begin
      if (on[p] && !p_rdwr[p]) begin
        for (int l = 0; l < 2; l++) begin
          if (ln[p][l]) begin
            if (on[1-p] && !p_rdwr[1-p] && ln[1-p][l] && eff[1-p] == eff[p])
              m_known[eff[p]][l] = 1'b0;
            else begin
              m_mem[eff[p]][l*8 +: 8] = p_wdata[p][l*8 +: 8];
              m_known[eff[p]][l] = 1'b1;
            end
          end
        end
      end
    end
    for (int p = 0; p < 2; p++) begin
      s2_l[p] = s1_l[p]; s2_d[p] = s1_d[p]; s2_k[p] = s1_k[p]; s2_t[p] = s1_t[p];
      s1_l[p] = nl[p];   s1_d[p] = nd[p];   s1_k[p] = nk[p];   s1_t[p] = nt[p];
      m_cnt[p] = eff[p];
    end
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      logic [1:0]        el, ek, ed;
      logic [DATA_W-1:0] edat;
      string             et;
      el   = p_pipe[p] ? s2_l[p] : s1_l[p];
      ek   = p_pipe[p] ? s2_k[p] : s1_k[p];
      edat = p_pipe[p] ? s2_d[p] : s1_d[p];
      et   = p_pipe[p] ? s2_t[p] : s1_t[p];
      ed   = p_oen[p] ? 2'b00 : el;
      chk($sformatf("%s R3 R4 R6 port%0d drive", et, p), 32'(o_drive[p]), 32'(ed));
      for (int l = 0; l < 2; l++)
        if (ed[l] && ek[l])
          chk($sformatf("%s R4 port%0d lane%0d data", et, p, l),
              32'(o_rdata[p][l*8 +: 8]), 32'(edat[l*8 +: 8]));
    end
  endtask

  task automatic rand_port(input int p);
    p_clr_n[p]  = ($urandom_range(0, 15) != 0);
    p_load_n[p] = ($urandom_range(0, 1) == 0);
    p_adv_n[p]  = ($urandom_range(0, 1) == 0);
    p_addr[p]   = ($urandom_range(0, 3) == 0) ? ADDR_W'(DEPTH - 1 - $urandom_range(0, 2))
                                               : ADDR_W'($urandom_range(0, 15));
    p_sel_n[p]  = ($urandom_range(0, 7) == 0);
    p_sel[p]    = ($urandom_range(0, 7) != 0);
    p_rdwr[p]   = ($urandom_range(0, 1) == 0);
    p_hi_n[p]   = ($urandom_range(0, 3) == 0);
    p_lo_n[p]   = ($urandom_range(0, 3) == 0);
    p_wdata[p]  = DATA_W'($urandom);
    p_oen[p]    = ($urandom_range(0, 7) == 0);
    p_pipe[p]   = ($urandom_range(0, 1) == 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd5171));
    for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_known[i] = 2'b00; end
    for (int p = 0; p < 2; p++) begin
      m_cnt[p] = '0; s1_l[p] = '0; s2_l[p] = '0; s1_k[p] = '0; s2_k[p] = '0;
      s1_d[p] = '0; s2_d[p] = '0; s1_t[p] = "reset"; s2_t[p] = "reset";
      idle(p, 1'b0);
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R13: reset state, no lanes driven
    chk("R13 reset port0 drive", 32'(o_drive[0]), 32'd0);
    chk("R13 reset port1 drive", 32'(o_drive[1]), 32'd0);
    rst_n = 1'b1;

    // Preload through port B
    idle(0, 1'b0);
    drv(1, 1, 0, 1, 5, 1, 0, 0, 0, 16'h0505, 0, 0); step();
    drv(1, 1, 0, 1, 1, 1, 0, 0, 0, 16'h1111, 0, 0); step();
    drv(1, 1, 0, 1, 6, 1, 0, 0, 0, 16'h6666, 0, 0); step();
    drv(1, 1, 0, 1, 9, 1, 0, 0, 0, 16'h0909, 0, 0); step();

    // R10 wrap, R8 clear, R6 write with output enable high
    drv(0, 1, 0, 1, DEPTH - 1, 1, 0, 0, 0, 16'h1234, 1, 0);
    drv(1, 0, 1, 1, 77, 1, 0, 0, 0, 16'hA5A5, 0, 0); step();
    drv(0, 1, 1, 1, 0, 1, 1, 0, 0, '0, 0, 0); idle(1, 0); step();
    chk("R6 write with output disabled kept", 32'(o_rdata[0]), 32'h1234);
    drv(0, 1, 1, 0, 0, 1, 1, 0, 0, '0, 0, 0); step();
    chk("R10 wrap drive", 32'(o_drive[0]), 32'd3);
    chk("R10 R8 wrap to word 0", 32'(o_rdata[0]), 32'hA5A5);

    // R12 load beats advance
    drv(0, 1, 0, 0, 5, 1, 1, 0, 0, '0, 0, 0); step();
    chk("R12 load priority", 32'(o_rdata[0]), 32'h0505);

    // R11 counter advances while deselected
    drv(0, 1, 1, 0, 0, 0, 1, 1, 1, '0, 0, 0); step();
    chk("R3 deselected read drive", 32'(o_drive[0]), 32'd0);
    drv(0, 1, 1, 1, 0, 1, 1, 0, 0, '0, 0, 0); step();
    chk("R11 advance while deselected", 32'(o_rdata[0]), 32'h6666);

    // R3 deselected write ignored (low enable high, then high enable low)
    drv(0, 1, 1, 1, 0, 0, 0, 0, 0, 16'hDEAD, 0, 0); step();
    drv(0, 1, 1, 1, 0, 1, 0, 0, 0, 16'hBEEF, 0, 0); p_sel_n[0] = 1'b0; p_sel[0] = 1'b0; step();
    drv(0, 1, 1, 1, 0, 1, 1, 0, 0, '0, 0, 0); step();
    chk("R3 deselected write ignored", 32'(o_rdata[0]), 32'h6666);

    // R4 byte lanes
    drv(0, 1, 1, 1, 0, 1, 0, 1, 0, 16'hFFCC, 0, 0); step();
    drv(0, 1, 1, 1, 0, 1, 1, 0, 1, '0, 0, 0); step();
    chk("R4 upper-only drive", 32'(o_drive[0]), 32'd2);
    chk("R4 upper lane kept", 32'(o_rdata[0][15:8]), 32'h66);
    drv(0, 1, 1, 1, 0, 1, 1, 1, 1, '0, 0, 0); step();
    chk("R4 no lane selected drive", 32'(o_drive[0]), 32'd0);
    drv(0, 1, 1, 1, 0, 1, 1, 0, 0, '0, 0, 0); step();
    chk("R4 lower lane written", 32'(o_rdata[0]), 32'h66CC);

    // R6 asynchronous output enable
    drv(0, 1, 1, 1, 0, 1, 1, 0, 0, '0, 1, 0); step();
    chk("R6 output disabled", 32'(o_drive[0]), 32'd0);
    p_oen[0] = 1'b0; #1;
    chk("R6 async enable drive", 32'(o_drive[0]), 32'd3);
    chk("R6 async enable data", 32'(o_rdata[0]), 32'h66CC);

    // R7 pipelined and flow-through timing
    idle(0, 1'b1); step();
    drv(0, 1, 0, 1, 5, 1, 1, 0, 0, '0, 0, 1); step();
    chk("R7 pipelined not yet driven", 32'(o_drive[0]), 32'd0);
    idle(0, 1'b1); step();
    chk("R7 pipelined drive", 32'(o_drive[0]), 32'd3);
    chk("R7 pipelined data", 32'(o_rdata[0]), 32'h0505);
    drv(0, 1, 0, 1, 5, 1, 1, 0, 0, '0, 0, 0); step();
    chk("R7 flow-through data", 32'(o_rdata[0]), 32'h0505);

    // R1 same-word access from both ports
    drv(0, 1, 0, 1, 9, 1, 0, 0, 0, 16'h9999, 0, 0);
    drv(1, 1, 0, 1, 9, 1, 1, 0, 0, '0, 0, 0); step();
    chk("R1 same-cycle read gets old word", 32'(o_rdata[1]), 32'h0909);
    idle(0, 1'b0); drv(1, 1, 1, 1, 0, 1, 1, 0, 0, '0, 0, 0); step();
    chk("R1 cross-port readback", 32'(o_rdata[1]), 32'h9999);

    // Constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      rand_port(0);
      rand_port(1);
      step();
    end

    done = 1;
    finish_run();
  end

endmodule